// File: doc/BRIEF.md
# Console Character I/O Register Block

This block is a load/store slave that claims a reserved window at the top of the address space and turns it into four word registers. Two of them serve a character source such as a keyboard, and the other two serve a character sink such as a display. Software polls a ready bit in a status word, then moves one byte through the matching data word. Each ready bit is seen from the processor's side. The receive ready bit means "a byte is waiting to be loaded". The transmit ready bit means "a byte may be stored now". Each bit clears itself when the data word is accessed, so no separate acknowledge write is needed.

The processor side is a single-cycle port. Read data is combinational while a load is presented, and the side effects take place at the clock edge that completes the access. The device side has two ports. A valid/data strobe delivers received bytes. A ready input tells the block that the sink can take a byte, and a one-cycle strobe carries the stored byte out.

Register map, with word offsets from the window base (default base 0xFFFF0000, window 64 KiB):

| Offset | Register |
|---|---|
| 0x0 | receive status |
| 0x4 | receive data |
| 0x8 | transmit status |
| 0xC | transmit data |

Address bits 1:0 are ignored.

Top module: `console_mmio`

## Requirements
- R1: After reset, the receive ready bit, the overrun bit and the transmit ready bit are all 0, and `disp_valid_o` is low.
- R2: A cycle with `kb_valid_i` high latches `kb_data_i` and sets the receive ready bit. This is bit 0 of the word at offset 0x0, and it reads 1 from the next cycle on.
- R3: A load from offset 0x4 returns the held byte in bits 7:0 with bits 31:8 zero. At that clock edge it clears both the receive ready bit and the overrun bit.
- R4: A byte that arrives while the receive ready bit is 1 replaces the held byte and sets the overrun bit, bit 1 of offset 0x0. The overrun bit stays set until the next load from offset 0x4.
- R5: A cycle with `disp_ready_i` high sets the transmit ready bit, bit 0 of offset 0x8, which reads 1 from the next cycle on.
- R6: A store to offset 0xC while the transmit ready bit is 1 raises `disp_valid_o` for exactly one cycle in the following cycle. In that cycle `disp_data_o` equals bits 7:0 of the stored word. The same store clears the transmit ready bit.
- R7: A store to offset 0xC while the transmit ready bit is 0 is dropped. `disp_valid_o` stays low, and `disp_data_o` keeps the last byte that was accepted.
- R8: Stores to offsets 0x0 and 0x8 change no state. Status bits other than those named in R2, R4 and R5 read 0.
- R9: Loads from unused offsets inside the window (0x10 and up) and from any address outside the window return 0. Such loads clear no flag.
- R10: When a byte arrives in the same cycle as a load from offset 0x4, the load returns the old byte. The new byte is then held with receive ready 1 and overrun 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Access request this cycle |
| bus_we_i | input | 1 | 1 = store, 0 = load |
| bus_addr_i | input | 32 | Byte address |
| bus_wdata_i | input | 32 | Store data |
| bus_rdata_o | output | 32 | Load data, valid while a load is presented |
| kb_valid_i | input | 1 | Received byte strobe |
| kb_data_i | input | 8 | Received byte |
| disp_ready_i | input | 1 | Sink can take a byte |
| disp_valid_o | output | 1 | One-cycle transmit strobe |
| disp_data_o | output | 8 | Transmitted byte |

## Verification
The checker assumes that every access lasts a single cycle and that `bus_we_i` is meaningful only while `bus_req_i` is high. It also assumes that `kb_valid_i` is a per-cycle strobe, with one byte delivered for each high cycle. The bench drives every bus access and device strobe from the falling edge for exactly one cycle, and returns the request to idle before the next access. It raises `disp_ready_i` only for single cycles, so the transmit ready bit never sets again in the cycle right after a store unless the bench intends it to.

// File: rtl/console_mmio_pkg.sv
package console_mmio_pkg;
  localparam int unsigned CHAR_W = 8;

  typedef enum logic [1:0] {
    SLOT_RX_STAT = 2'd0,
    SLOT_RX_DATA = 2'd1,
    SLOT_TX_STAT = 2'd2,
    SLOT_TX_DATA = 2'd3
  } slot_e;
endpackage

// File: rtl/console_addr_dec.sv
module console_addr_dec
  import console_mmio_pkg::*;
#(
  parameter int unsigned          ADDR_W    = 32,
  parameter logic [ADDR_W-1:0]    BASE      = 32'hFFFF_0000,
  parameter int unsigned          SPAN_LOG2 = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output slot_e             slot_o
);
  localparam int unsigned SLOT_LSB = 2;
  localparam int unsigned SLOT_MSB = 3;

  logic in_window;
  logic in_slots;
  logic unused_lo;

  assign in_window = (addr_i[ADDR_W-1:SPAN_LOG2] == BASE[ADDR_W-1:SPAN_LOG2]);
  assign in_slots  = (addr_i[SPAN_LOG2-1:SLOT_MSB+1] == '0);
  assign hit_o     = in_window && in_slots;
  assign slot_o    = slot_e'(addr_i[SLOT_MSB:SLOT_LSB]);
  assign unused_lo = ^addr_i[SLOT_LSB-1:0];
endmodule

// File: rtl/console_rx_chan.sv
module console_rx_chan #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [CHAR_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic              rdy_o,
  output logic              ovr_o,
  output logic [CHAR_W-1:0] data_o
);
  logic              rdy_q, ovr_q;
  logic [CHAR_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q  <= 1'b0;
      ovr_q  <= 1'b0;
      data_q <= '0;
    end else if (push_i) begin
      data_q <= push_data_i;
      rdy_q  <= 1'b1;
      // a pop in the same cycle consumed the old byte: no loss
      ovr_q  <= (rdy_q | ovr_q) & ~pop_i;
    end else if (pop_i) begin
      rdy_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end
  end

  assign rdy_o  = rdy_q;
  assign ovr_o  = ovr_q;
  assign data_o = data_q;
endmodule

// File: rtl/console_tx_chan.sv
module console_tx_chan #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              store_i,
  input  logic [CHAR_W-1:0] store_data_i,
  input  logic              dev_ready_i,
  output logic              rdy_o,
  output logic              strobe_o,
  output logic [CHAR_W-1:0] data_o
);
  logic              rdy_q, strobe_q;
  logic [CHAR_W-1:0] data_q;
  logic              accept;

  assign accept = store_i & rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q    <= 1'b0;
      strobe_q <= 1'b0;
      data_q   <= '0;
    end else begin
      rdy_q    <= accept ? 1'b0 : (rdy_q | dev_ready_i);
      strobe_q <= accept;
      if (accept) data_q <= store_data_i;
    end
  end

  assign rdy_o    = rdy_q;
  assign strobe_o = strobe_q;
  assign data_o   = data_q;
endmodule

// File: rtl/console_mmio.sv
module console_mmio
  import console_mmio_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       DATA_W    = 32,
  parameter logic [ADDR_W-1:0] BASE      = 32'hFFFF_0000,
  parameter int unsigned       SPAN_LOG2 = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              kb_valid_i,
  input  logic [CHAR_W-1:0] kb_data_i,
  input  logic              disp_ready_i,
  output logic              disp_valid_o,
  output logic [CHAR_W-1:0] disp_data_o
);
  logic              hit;
  slot_e             slot;
  logic              rd_acc, wr_acc;
  logic              in_rdy, in_ovr, out_rdy;
  logic [CHAR_W-1:0] in_data;
  logic              unused_wdata;

  console_addr_dec #(
    .ADDR_W   (ADDR_W),
    .BASE     (BASE),
    .SPAN_LOG2(SPAN_LOG2)
  ) u_dec (
    .addr_i(bus_addr_i),
    .hit_o (hit),
    .slot_o(slot)
  );

  assign rd_acc       = bus_req_i & ~bus_we_i & hit;
  assign wr_acc       = bus_req_i &  bus_we_i & hit;
  assign unused_wdata = ^bus_wdata_i[DATA_W-1:CHAR_W];

  console_rx_chan #(.CHAR_W(CHAR_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (kb_valid_i),
    .push_data_i(kb_data_i),
    .pop_i      (rd_acc && slot == SLOT_RX_DATA),
    .rdy_o      (in_rdy),
    .ovr_o      (in_ovr),
    .data_o     (in_data)
  );

  console_tx_chan #(.CHAR_W(CHAR_W)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .store_i     (wr_acc && slot == SLOT_TX_DATA),
    .store_data_i(bus_wdata_i[CHAR_W-1:0]),
    .dev_ready_i (disp_ready_i),
    .rdy_o       (out_rdy),
    .strobe_o    (disp_valid_o),
    .data_o      (disp_data_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (rd_acc) begin
      unique case (slot)
        SLOT_RX_STAT: bus_rdata_o[1:0]        = {in_ovr, in_rdy};
        SLOT_RX_DATA: bus_rdata_o[CHAR_W-1:0] = in_data;
        SLOT_TX_STAT: bus_rdata_o[0]          = out_rdy;
        SLOT_TX_DATA: bus_rdata_o[CHAR_W-1:0] = disp_data_o;
        default:      bus_rdata_o             = '0;
      endcase
    end
  end
endmodule

// File: rtl/console_mmio_chk.sv
module console_mmio_chk #(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       DATA_W    = 32,
  parameter logic [ADDR_W-1:0] BASE      = 32'hFFFF_0000,
  parameter int unsigned       SPAN_LOG2 = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [7:0]        wbyte_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              kb_valid_i,
  input logic              disp_valid_o,
  input logic [7:0]        disp_data_o,
  input logic              in_rdy,
  input logic              in_ovr,
  input logic              out_rdy
);
  logic in_win, rd_in, wr_out;

  assign in_win = (bus_addr_i[ADDR_W-1:SPAN_LOG2] == BASE[ADDR_W-1:SPAN_LOG2])
               && (bus_addr_i[SPAN_LOG2-1:4] == '0);
  assign rd_in  = bus_req_i && !bus_we_i && in_win && bus_addr_i[3:2] == 2'd1;
  assign wr_out = bus_req_i &&  bus_we_i && in_win && bus_addr_i[3:2] == 2'd3;

  a_r2_arrival_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kb_valid_i |=> in_rdy);

  a_r3_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_in && !kb_valid_i |=> !in_rdy && !in_ovr);

  a_r3_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[DATA_W-1:8] == '0);

  a_r4_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kb_valid_i && in_rdy && !rd_in |=> in_ovr);

  a_r6_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_out && out_rdy |=> disp_valid_o && disp_data_o == $past(wbyte_i) && !out_rdy);

  a_r7_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_out && !out_rdy |=> !disp_valid_o);

  a_r10_simul: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_in && kb_valid_i |=> in_rdy && !in_ovr);
endmodule

bind console_mmio console_mmio_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .BASE     (BASE),
  .SPAN_LOG2(SPAN_LOG2)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .wbyte_i     (bus_wdata_i[7:0]),
  .bus_rdata_o (bus_rdata_o),
  .kb_valid_i  (kb_valid_i),
  .disp_valid_o(disp_valid_o),
  .disp_data_o (disp_data_o),
  .in_rdy      (in_rdy),
  .in_ovr      (in_ovr),
  .out_rdy     (out_rdy)
);

// File: tb/console_mmio_test.sv
module console_mmio_test;
  localparam logic [31:0] B = 32'hFFFF_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_req_i = 1'b0, bus_we_i = 1'b0;
  logic [31:0] bus_addr_i = '0, bus_wdata_i = '0, bus_rdata_o;
  logic        kb_valid_i = 1'b0;
  logic [7:0]  kb_data_i = '0;
  logic        disp_ready_i = 1'b0, disp_valid_o;
  logic [7:0]  disp_data_o;

  int n_run = 0, n_fail = 0;
  logic [31:0] rd;

  always #2 clk_i = ~clk_i;

  console_mmio uut (.*);

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_read(logic [31:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_req_i = 1; bus_we_i = 0; bus_addr_i = a;
    #1 d = bus_rdata_o;
    @(negedge clk_i);
    bus_req_i = 0; bus_addr_i = '0;
  endtask

  task automatic bus_write(logic [31:0] a, logic [31:0] w);
    @(negedge clk_i);
    bus_req_i = 1; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = w;
    @(negedge clk_i);
    bus_req_i = 0; bus_we_i = 0; bus_addr_i = '0; bus_wdata_i = '0;
  endtask

  task automatic kb_push(logic [7:0] b);
    @(negedge clk_i);
    kb_valid_i = 1; kb_data_i = b;
    @(negedge clk_i);
    kb_valid_i = 0;
  endtask

  task automatic make_tx_ready();
    @(negedge clk_i);
    disp_ready_i = 1;
    @(negedge clk_i);
    disp_ready_i = 0;
  endtask

  task automatic t_reset();
    check("R1 disp_valid", {31'b0, disp_valid_o}, 0);
    bus_read(B + 0, rd); check("R1 rx status", rd, 0);
    bus_read(B + 8, rd); check("R1 tx status", rd, 0);
  endtask

  task automatic t_rx_basic();
    kb_push(8'hA5);
    bus_read(B + 0, rd); check("R2 rx ready", rd, 1);
    bus_read(B + 4, rd); check("R3 rx data", rd, 32'hA5);
    bus_read(B + 0, rd); check("R3 cleared", rd, 0);
  endtask

  task automatic t_overrun();
    kb_push(8'h11);
    kb_push(8'h22);
    bus_read(B + 0, rd); check("R4 overrun set", rd, 3);
    bus_read(B + 0, rd); check("R4 sticky", rd, 3);
    bus_read(B + 4, rd); check("R4 newest byte", rd, 32'h22);
    bus_read(B + 0, rd); check("R4 overrun cleared", rd, 0);
  endtask

  task automatic t_tx();
    make_tx_ready();
    bus_read(B + 8, rd); check("R5 tx ready", rd, 1);
    bus_write(B + 12, 32'hFFFF_FF5A);
    check("R6 strobe", {31'b0, disp_valid_o}, 1);
    check("R6 byte", {24'b0, disp_data_o}, 32'h5A);
    @(negedge clk_i);
    check("R6 single pulse", {31'b0, disp_valid_o}, 0);
    bus_read(B + 8, rd); check("R6 tx ready cleared", rd, 0);
  endtask

  task automatic t_tx_drop();
    bus_write(B + 12, 32'h0000_00C3);
    check("R7 no strobe", {31'b0, disp_valid_o}, 0);
    @(negedge clk_i);
    check("R7 no strobe later", {31'b0, disp_valid_o}, 0);
    check("R7 byte kept", {24'b0, disp_data_o}, 32'h5A);
  endtask

  task automatic t_ctrl_ignored();
    kb_push(8'h33);
    bus_write(B + 0, 32'h0);
    bus_read(B + 0, rd); check("R8 rx status unchanged", rd, 1);
    bus_write(B + 8, 32'hFFFF_FFFF);
    bus_read(B + 8, rd); check("R8 tx status unchanged", rd, 0);
    bus_read(B + 4, rd); check("R8 byte intact", rd, 32'h33);
  endtask

  task automatic t_unmapped();
    kb_push(8'h44);
    bus_read(B + 32'h10, rd);   check("R9 unused offset", rd, 0);
    bus_read(B + 32'h1004, rd); check("R9 alias offset", rd, 0);
    bus_read(32'h0000_0004, rd); check("R9 outside window", rd, 0);
    bus_read(B + 0, rd); check("R9 flag kept", rd, 1);
    bus_read(B + 4, rd); check("R9 byte kept", rd, 32'h44);
  endtask

  task automatic t_simul();
    kb_push(8'h55);
    @(negedge clk_i);
    bus_req_i = 1; bus_we_i = 0; bus_addr_i = B + 4;
    kb_valid_i = 1; kb_data_i = 8'h66;
    #1 rd = bus_rdata_o;
    @(negedge clk_i);
    bus_req_i = 0; bus_addr_i = '0; kb_valid_i = 0;
    check("R10 old byte returned", rd, 32'h55);
    bus_read(B + 0, rd); check("R10 ready no overrun", rd, 1);
    bus_read(B + 4, rd); check("R10 new byte", rd, 32'h66);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_rx_basic();
    t_overrun();
    t_tx();
    t_tx_drop();
    t_ctrl_ignored();
    t_unmapped();
    t_simul();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule